// File: doc/BRIEF.md
# Power-State Sequencer

This block decides when the clocks of a small processor run. A one-cycle sleep strobe from the core, together with three control bits, selects one of four stopped states. The three bits are I/O stop, standby select and quick. In these states the core, DMA, on-chip I/O, the clock output pin and the oscillator are gated in different groups. A separate I/O-stop level, given without a strobe, gates only the on-chip I/O while the core keeps running.

Leaving a stopped state needs a qualified wake request: NMI, or an external interrupt line whose own enable bit is set. An internal I/O interrupt also counts, but only in the light sleep state. The core clock returns after a fixed restart delay. In standby the oscillator must restart first, so the delay is much longer. That wait is cancelled if every request drops before it ends. On wake, the block gives a one-cycle pulse. With it goes a flag that says whether the core should take the interrupt or simply resume after the sleep instruction.

The block can also hand the bus to an external master while the core is asleep. In the deep states this is allowed only when a bus-release enable bit is set, and it is delayed.

Top module: `pwr_mode_seq`

## Requirements
- R1: An asynchronous reset puts the block in the running state. With io_stop=0 all six enables (cpu, dma, io, phi, osc, refresh) read 1, bus_grant=0 and wake_pulse=0.
- R2: While running, io_stop=1 without a strobe clears only io_clk_en. Setting io_stop back to 0 restores it.
- R3: A strobe with io_stop=0 enters light sleep, whatever stby_sel and quick are. In light sleep cpu, dma and refresh are 0 and io, phi and osc are 1.
- R4: A strobe with io_stop=1, stby_sel=0, quick=0 enters system stop: only phi and osc stay 1. io_irq does not wake this state.
- R5: A strobe with io_stop=1, stby_sel=0, quick=1 enters idle: only osc stays 1. io_irq does not wake this state.
- R6: A strobe with io_stop=1 and stby_sel=1 enters standby: all six enables are 0.
- R7: The wake request is nmi, or ext_irq[i] with ext_irq_en[i]=1. In light sleep only, io_irq also counts. A line whose enable bit is 0 never wakes the block.
- R8: The edge that first samples a wake request is the sample edge. The core enables rise 2 edges after it from light sleep or system stop, and 10 edges after it from idle. From standby they rise 64 edges after it if quick was 1 at entry, else 131072. osc is 1 from the edge after the sample edge.
- R9: In the standby wait, if the wake request and the qualified bus request are both low at an edge, the block returns to standby with osc=0.
- R10: wake_pulse is 1 for exactly the first running cycle after a wake. wake_irq then equals nmi OR ien_global, sampled when the wake is decided.
- R11: In running, light sleep and system stop, bus_grant follows bus_req one edge later. In idle and standby, a bus request is ignored unless bus_rel_en=1.
- R12: In idle with bus_rel_en=1, bus_grant rises 8 edges after the edge that samples bus_req, and phi is 1 while granted. When bus_req drops, grant and phi fall and the block stays in idle. A wake request sampled during this wait takes precedence over the grant.
- R13: In standby with bus_rel_en=1, the grant comes after the same 64 or 131072 edge wait, with osc and phi at 1. When bus_req drops, the block returns to standby with osc=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slp_strobe | input | 1 | One-cycle sleep request from the core |
| io_stop | input | 1 | I/O stop control bit |
| stby_sel | input | 1 | Standby select bit |
| quick | input | 1 | Idle select / short recovery bit |
| ien_global | input | 1 | Global interrupt enable flag |
| ext_irq_en | input | N_EXT | Per-line external interrupt enables |
| ext_irq | input | N_EXT | External interrupt requests, active high |
| nmi | input | 1 | Non-maskable interrupt request |
| io_irq | input | 1 | Internal I/O interrupt request |
| bus_req | input | 1 | External master bus request |
| bus_rel_en | input | 1 | Allows bus release in idle and standby |
| cpu_clk_en | output | 1 | Core clock enable |
| dma_clk_en | output | 1 | DMA clock enable |
| io_clk_en | output | 1 | On-chip I/O clock enable |
| phi_en | output | 1 | Clock output pin enable |
| osc_en | output | 1 | Oscillator run enable |
| refresh_en | output | 1 | DRAM refresh enable |
| bus_grant | output | 1 | Bus granted to external master |
| wake_pulse | output | 1 | One-cycle wake indication |
| wake_irq | output | 1 | 1: take interrupt, 0: resume after sleep |

## Verification
In idle, a bus request waiting out its 8-edge lag and an interrupt wake can reach the state logic at the same edge. The bench raises bus_req and an enabled ext_irq line on the same negative edge. It then judges that the core restarts exactly 10 edges later, and that the restart is not held back by the pending grant. A similar overlap comes up in the standby wait, where a cancel and the terminal count compete. The bench drops the request part-way through the wait and checks that osc falls one edge later and the core stays stopped.

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq #(
  parameter int LONG_WAIT    = 131072,
  parameter int SHORT_WAIT   = 64,
  parameter int SLEEP_EXIT   = 2,
  parameter int IDLE_EXIT    = 10,
  parameter int IDLE_BUS_LAG = 8,
  parameter int N_EXT        = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slp_strobe,
  input  logic             io_stop,
  input  logic             stby_sel,
  input  logic             quick,
  input  logic             ien_global,
  input  logic [N_EXT-1:0] ext_irq_en,
  input  logic [N_EXT-1:0] ext_irq,
  input  logic             nmi,
  input  logic             io_irq,
  input  logic             bus_req,
  input  logic             bus_rel_en,
  output logic             cpu_clk_en,
  output logic             dma_clk_en,
  output logic             io_clk_en,
  output logic             phi_en,
  output logic             osc_en,
  output logic             refresh_en,
  output logic             bus_grant,
  output logic             wake_pulse,
  output logic             wake_irq
);

  localparam int CW = $clog2(LONG_WAIT);
  localparam logic [CW-1:0] T_LONG  = CW'(LONG_WAIT - 1);
  localparam logic [CW-1:0] T_SHORT = CW'(SHORT_WAIT - 1);
  localparam logic [CW-1:0] T_SLEEP = CW'(SLEEP_EXIT - 1);
  localparam logic [CW-1:0] T_IDLE  = CW'(IDLE_EXIT - 1);
  localparam logic [CW-1:0] T_BUS   = CW'(IDLE_BUS_LAG - 1);

  typedef enum logic [3:0] {
    S_RUN, S_SLEEP, S_SSTOP, S_IDLE, S_IDLE_BW, S_IDLE_BG,
    S_STBY, S_STBY_W, S_STBY_G, S_WAKE
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt, tgt;
  logic          quick_q, gnt_q, pulse_q, irq_q;

  wire wk_ext   = nmi | (|(ext_irq & ext_irq_en));
  wire wk_sleep = wk_ext | io_irq;
  wire take     = nmi | ien_global;
  wire bus_ok   = bus_req & bus_rel_en;
  wire done     = (cnt == tgt);
  wire runlike  = (st == S_RUN) || (st == S_SLEEP) || (st == S_SSTOP) || (st == S_WAKE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_RUN;
      cnt     <= '0;
      tgt     <= '0;
      quick_q <= 1'b0;
      gnt_q   <= 1'b0;
      pulse_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      gnt_q   <= runlike & bus_req;
      cnt     <= cnt + 1'b1;
      case (st)
        S_RUN:
          if (slp_strobe) begin
            if (!io_stop)     st <= S_SLEEP;
            else if (stby_sel) begin
              st      <= S_STBY;
              quick_q <= quick;
            end
            else if (quick)   st <= S_IDLE;
            else              st <= S_SSTOP;
          end
        S_SLEEP:
          if (wk_sleep) begin
            st <= S_WAKE; cnt <= '0; tgt <= T_SLEEP; irq_q <= take;
          end
        S_SSTOP:
          if (wk_ext) begin
            st <= S_WAKE; cnt <= '0; tgt <= T_SLEEP; irq_q <= take;
          end
        S_IDLE:
          if (wk_ext) begin
            st <= S_WAKE; cnt <= '0; tgt <= T_IDLE; irq_q <= take;
          end else if (bus_ok) begin
            st <= S_IDLE_BW; cnt <= '0; tgt <= T_BUS;
          end
        S_IDLE_BW:
          if (wk_ext) begin
            st <= S_WAKE; cnt <= '0; tgt <= T_IDLE; irq_q <= take;
          end else if (!bus_req) st <= S_IDLE;
          else if (done)         st <= S_IDLE_BG;
        S_IDLE_BG:
          if (!bus_req) st <= S_IDLE;
        S_STBY:
          if (wk_ext || bus_ok) begin
            st  <= S_STBY_W;
            cnt <= '0;
            tgt <= quick_q ? T_SHORT : T_LONG;
          end
        S_STBY_W:
          if (!wk_ext && !bus_ok) st <= S_STBY;
          else if (done) begin
            if (wk_ext) begin
              st <= S_RUN; pulse_q <= 1'b1; irq_q <= take;
            end else st <= S_STBY_G;
          end
        S_STBY_G:
          if (!bus_req) st <= S_STBY;
        S_WAKE:
          if (done) begin
            st <= S_RUN; pulse_q <= 1'b1;
          end
        default: st <= S_RUN;
      endcase
    end
  end

  assign cpu_clk_en = (st == S_RUN);
  assign dma_clk_en = (st == S_RUN);
  assign refresh_en = (st == S_RUN);
  assign io_clk_en  = (st == S_SLEEP) || (((st == S_RUN) || (st == S_WAKE)) && !io_stop);
  assign phi_en     = runlike || (st == S_IDLE_BG) || (st == S_STBY_G);
  assign osc_en     = (st != S_STBY);
  assign bus_grant  = (runlike && gnt_q) || (st == S_IDLE_BG) || (st == S_STBY_G);
  assign wake_pulse = pulse_q;
  assign wake_irq   = irq_q;

  a_r3_sleep_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && slp_strobe && !io_stop) |=> (!cpu_clk_en && io_clk_en && phi_en && !refresh_en));

  a_r6_stby_osc_off: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && slp_strobe && io_stop && stby_sel) |=> (!osc_en && !phi_en));

  a_r4_io_irq_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SSTOP && !wk_ext) |=> (!cpu_clk_en && !io_clk_en));

  a_r9_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STBY_W && !wk_ext && !bus_ok) |=> !osc_en);

  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STBY_W || st == S_WAKE || st == S_IDLE_BW) |-> (cnt <= tgt));

  a_r10_pulse_first_run: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> (cpu_clk_en && $past(!cpu_clk_en)));

  a_r11_no_release: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_IDLE || st == S_STBY) && !bus_rel_en) |=> !bus_grant);

endmodule

// File: tb/tb_pwr_mode_seq.sv
module tb_pwr_mode_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic slp_strobe = 0, io_stop = 0, stby_sel = 0, quick = 0, ien_global = 0;
  logic [2:0] ext_irq_en = 0, ext_irq = 0;
  logic nmi = 0, io_irq = 0, bus_req = 0, bus_rel_en = 0;
  logic cpu_clk_en, dma_clk_en, io_clk_en, phi_en, osc_en, refresh_en;
  logic bus_grant, wake_pulse, wake_irq;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_seq dut (
    .clk(clk), .rst_n(rst_n), .slp_strobe(slp_strobe), .io_stop(io_stop),
    .stby_sel(stby_sel), .quick(quick), .ien_global(ien_global),
    .ext_irq_en(ext_irq_en), .ext_irq(ext_irq), .nmi(nmi), .io_irq(io_irq),
    .bus_req(bus_req), .bus_rel_en(bus_rel_en), .cpu_clk_en(cpu_clk_en),
    .dma_clk_en(dma_clk_en), .io_clk_en(io_clk_en), .phi_en(phi_en),
    .osc_en(osc_en), .refresh_en(refresh_en), .bus_grant(bus_grant),
    .wake_pulse(wake_pulse), .wake_irq(wake_irq)
  );

  wire [5:0] en_vec = {cpu_clk_en, dma_clk_en, io_clk_en, phi_en, osc_en, refresh_en};

  // {io_stop, stby_sel, quick} , {cpu,dma,io,phi,osc,refresh}
  localparam logic [8:0] MODE_TBL [8] = '{
    9'b000_001110, 9'b001_001110, 9'b010_001110, 9'b011_001110,
    9'b100_000110, 9'b101_000010, 9'b110_000000, 9'b111_000000
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; slp_strobe = 0; io_stop = 0; stby_sel = 0; quick = 0;
    ien_global = 0; ext_irq_en = 0; ext_irq = 0; nmi = 0; io_irq = 0;
    bus_req = 0; bus_rel_en = 0;
    tick(1);
    rst_n = 1;
  endtask

  task automatic enter(input logic [2:0] m);
    @(negedge clk);
    {io_stop, stby_sel, quick} = m;
    slp_strobe = 1;
    tick(1);
    slp_strobe = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state
    tick(1);
    chk("R1 enables in reset", en_vec, 6'b111111);
    chk("R1 grant in reset", bus_grant, 0);
    chk("R1 pulse in reset", wake_pulse, 0);
    rst_n = 1;
    tick(1);
    // R2 I/O stop level
    io_stop = 1; tick(1);
    chk("R2 io gated", en_vec, 6'b110111);
    io_stop = 0; tick(1);
    chk("R2 io restored", en_vec, 6'b111111);

    // R3-R6 mode decode table
    for (int i = 0; i < 8; i++) begin
      logic [2:0] m;
      string tag;
      m = MODE_TBL[i][8:6];
      tag = m[2] ? (m[1] ? "R6 standby" : (m[0] ? "R5 idle" : "R4 system stop")) : "R3 sleep";
      do_reset();
      enter(m);
      chk(tag, en_vec, MODE_TBL[i][5:0]);
    end

    // R7 disabled line ignored, R8 sleep latency, R10 interrupt response
    do_reset(); ext_irq_en = 3'b101;
    enter(3'b000);
    ext_irq = 3'b010; tick(5);
    chk("R7 disabled line no wake", cpu_clk_en, 0);
    ien_global = 1; ext_irq_en = 3'b111;
    tick(2); chk("R8 sleep exit not yet", cpu_clk_en, 0);
    tick(1); chk("R8 sleep exit after 2", cpu_clk_en, 1);
    chk("R10 pulse", wake_pulse, 1);
    chk("R10 take interrupt", wake_irq, 1);
    tick(1); chk("R10 pulse one cycle", wake_pulse, 0);
    ext_irq = 0;

    // R7 io_irq wakes light sleep, resume flag
    do_reset(); enter(3'b000);
    io_irq = 1; tick(3);
    chk("R7 io_irq wakes sleep", cpu_clk_en, 1);
    chk("R10 resume flag", wake_irq, 0);
    io_irq = 0;

    // R4 system stop ignores io_irq, nmi wakes
    do_reset(); enter(3'b100);
    io_irq = 1; tick(6);
    chk("R4 io_irq ignored", en_vec, 6'b000110);
    io_irq = 0; nmi = 1;
    tick(2); chk("R8 sstop exit not yet", cpu_clk_en, 0);
    tick(1); chk("R8 sstop exit", cpu_clk_en, 1);
    chk("R10 nmi forces interrupt", wake_irq, 1);
    nmi = 0;

    // R5 idle, R11 no release, R12 delayed grant
    do_reset(); enter(3'b101);
    io_irq = 1; tick(4);
    chk("R5 io_irq ignored in idle", en_vec, 6'b000010);
    io_irq = 0; bus_req = 1; tick(12);
    chk("R11 idle no release", bus_grant, 0);
    bus_rel_en = 1;
    tick(8); chk("R12 grant not yet", bus_grant, 0);
    tick(1); chk("R12 grant after lag", bus_grant, 1);
    chk("R12 phi during grant", phi_en, 1);
    bus_req = 0; tick(1);
    chk("R12 back to idle", {bus_grant, phi_en, cpu_clk_en}, 3'b000);
    ext_irq_en = 3'b001; ext_irq = 3'b001;
    tick(10); chk("R8 idle exit not yet", cpu_clk_en, 0);
    tick(1); chk("R8 idle exit after 10", cpu_clk_en, 1);
    chk("R10 resume from idle", wake_irq, 0);
    ext_irq = 0;
    // R11 normal grant
    bus_req = 1; tick(1);
    chk("R11 normal grant", bus_grant, 1);
    bus_req = 0; tick(1);
    chk("R11 normal release", bus_grant, 0);

    // R12 collision: bus request and wake on the same edge in idle
    do_reset(); enter(3'b101);
    bus_rel_en = 1; bus_req = 1; ext_irq_en = 3'b010; ext_irq = 3'b010;
    tick(10); chk("R12 collision not yet", cpu_clk_en, 0);
    tick(1); chk("R12 collision wake wins", cpu_clk_en, 1);
    bus_req = 0; ext_irq = 0;

    // R9 standby cancel, quick recovery
    do_reset(); enter(3'b111);
    ext_irq_en = 3'b111; ext_irq = 3'b100;
    tick(1); chk("R8 osc restarts", {osc_en, cpu_clk_en}, 2'b10);
    tick(19); ext_irq = 0;
    tick(1); chk("R9 cancel osc off", osc_en, 0);
    tick(100); chk("R9 still standby", en_vec, 6'b000000);
    ext_irq = 3'b100; ien_global = 1;
    tick(64); chk("R8 quick not yet", cpu_clk_en, 0);
    tick(1); chk("R8 quick exit 64", cpu_clk_en, 1);
    chk("R10 standby interrupt", {wake_pulse, wake_irq}, 2'b11);
    ext_irq = 0;

    // R13 standby grant, R11 no release
    do_reset(); enter(3'b111);
    bus_req = 1; tick(100);
    chk("R11 standby no release", {bus_grant, osc_en}, 2'b00);
    bus_rel_en = 1;
    tick(64); chk("R13 grant not yet", bus_grant, 0);
    tick(1); chk("R13 grant", {bus_grant, phi_en, osc_en, cpu_clk_en}, 4'b1110);
    bus_req = 0; tick(1);
    chk("R13 back to standby", {bus_grant, osc_en, phi_en}, 3'b000);

    // R8 long wait, quick latched at entry
    do_reset(); enter(3'b110);
    quick = 1; nmi = 1;
    tick(131072); chk("R8 long not yet", cpu_clk_en, 0);
    tick(1); chk("R8 long exit", cpu_clk_en, 1);
    nmi = 0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule